// File: doc/BRIEF.md
# SPI clock and delay timing generator

This block generates the serial clock and the chip-select framing for the master side of an SPI link. The SCK period is set by two selects, a prescaler code and a scaler code. The period in system clocks is the product of the two decoded values, and a double-rate option halves it. Two more prescaler and scaler pairs set how long chip select is asserted before the first SCK activity and how long it stays asserted after the last one. Each of those delays also counts system clocks equal to the product of its decoded pair.

A single-cycle start request runs one frame. The frame asserts chip select, waits the lead delay and produces the programmed number of SCK edges. It then waits the tail delay, releases chip select and pulses done. In continuous mode both delays are skipped and chip select stays asserted after the frame, so back-to-back frames share one chip-select window. A later non-continuous frame ends that window. Frames cannot start while a halt input is high. All settings are captured when a frame is accepted, so changes during a frame have no effect on it. Data shifting sits outside this block.

Top module: `spi_clk_timer`

## Requirements
- R1: Prescaler codes 0,1,2,3 decode to 2,3,5,7. Scaler codes 0,1,2,3 decode to 2,4,6,8, and codes 4 to 15 decode to 2 to the power of the code. With double rate off, the SCK period D is prescaler times scaler system clocks.
- R2: With `dbl_rate` high, D is half the product, so prescaler 2 and scaler 2 give an SCK period of 2 system clocks.
- R3: Each SCK high phase lasts (D+1)/2 system clocks and each low phase lasts D/2, so an odd D makes the high phase one clock longer. SCK comes from a register. Outside a frame, SCK follows `cpol` one cycle later.
- R4: A frame with N edges is made of N consecutive slots, each as long as the SCK phase it covers. With `cpha`=1, an edge opens each slot, so the first edge lands on the first slot's first cycle. With `cpha`=0, an edge closes each slot, so the first edge lands a phase later.
- R5: In a non-continuous frame, `cs_n` goes low at the edge that accepts start. The first slot begins lead-pair-product clocks later. After the last slot, `cs_n` stays low for tail-pair-product clocks and then goes high.
- R6: In continuous mode (`cont_cs`=1 at start), the first slot begins at the accepting edge and no tail delay is applied. `cs_n` remains low after the frame until a later non-continuous frame releases it.
- R7: `busy` is high from the accepting edge until the frame ends. `done` is a one-cycle pulse in the cycle the frame ends. That is the cycle `cs_n` returns high, or in continuous mode the cycle after the last slot.
- R8: While `queue_halt` is high, start is ignored: no frame begins and `cs_n` does not change.
- R9: A start during a frame is ignored. Selects, `cpha`, `cont_cs`, `dbl_rate` and `edge_num` are sampled only at the accepting edge.
- R10: With `edge_num`=0 there is no SCK edge. A non-continuous frame then holds `cs_n` low for the lead plus tail delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame request, one cycle |
| queue_halt | input | 1 | Blocks new frames while high |
| cont_cs | input | 1 | Continuous chip-select mode for the frame |
| dbl_rate | input | 1 | Halves the SCK period |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Edge placement within slots |
| sck_pre | input | 2 | SCK prescaler code |
| sck_scl | input | 4 | SCK scaler code |
| lead_pre | input | 2 | Lead delay prescaler code |
| lead_scl | input | 4 | Lead delay scaler code |
| tail_pre | input | 2 | Tail delay prescaler code |
| tail_scl | input | 4 | Tail delay scaler code |
| edge_num | input | EDGE_W | Number of SCK edges in a frame |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Frame in progress |
| done | output | 1 | End-of-frame pulse |

## Verification
The bench compares every cycle of `sck`, `cs_n`, `done` and `busy` against a model of the frame, so a wrong high/low split on an odd divide shows up as a shifted edge. Such a mistake would also move every later edge of the frame. The bench uses the fastest double-rate setting (a period of 2), the largest scaler code and both edge phases. A design that swapped `cpha` or applied the lead delay in continuous mode would have its whole edge train shifted in time. In the noisy frames, starts and new settings arrive mid-frame. A design that re-read the selects or restarted would then change its edge spacing or frame length. A design that dropped chip select between continuous frames, or let a halted start through, would change `cs_n` where the bench expects it to hold.

// File: rtl/spi_tmr_pkg.sv
package spi_tmr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LEAD  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_TAIL  = 2'd3
   } tmr_state_e;

   // largest decoded factors
   localparam int PRE_MAX = 7;
   localparam int SCL_MAX = 32768;

   function automatic logic [2:0] pre_val(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd2;
         2'd1:    return 3'd3;
         2'd2:    return 3'd5;
         default: return 3'd7;
      endcase
   endfunction

   function automatic logic [15:0] scl_val(input logic [3:0] code);
      if (code < 4'd4) return {11'd0, code + 4'd1, 1'b0};
      else             return 16'd1 << code;
   endfunction

endpackage

// File: rtl/spi_tmr_ratio.sv
module spi_tmr_ratio
   import spi_tmr_pkg::*;
#(
   parameter int CNT_W    = 18,
   parameter bit HALVE_EN = 1'b1
) (
   input  logic [1:0]       pre,
   input  logic [3:0]       scl,
   input  logic             halve,
   output logic [CNT_W-1:0] len
);

   logic [CNT_W-1:0] full;

   assign full = CNT_W'(pre_val(pre)) * CNT_W'(scl_val(scl));

   generate
      if (HALVE_EN) begin : g_halve
         assign len = halve ? (full >> 1) : full;
      end else begin : g_plain
         logic unused_halve;
         assign unused_halve = halve;
         assign len = full;
      end
   endgenerate

endmodule

// File: rtl/spi_tmr_dncnt.sv
module spi_tmr_dncnt #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= load_val;
      else if (cnt != '0)     cnt <= cnt - W'(1);
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/spi_clk_timer.sv
module spi_clk_timer
   import spi_tmr_pkg::*;
#(
   parameter int EDGE_W   = 6,
   parameter int CNT_W    = 18,
   parameter bit HALVE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              queue_halt,
   input  logic              cont_cs,
   input  logic              dbl_rate,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [1:0]        sck_pre,
   input  logic [3:0]        sck_scl,
   input  logic [1:0]        lead_pre,
   input  logic [3:0]        lead_scl,
   input  logic [1:0]        tail_pre,
   input  logic [3:0]        tail_scl,
   input  logic [EDGE_W-1:0] edge_num,
   output logic              sck,
   output logic              cs_n,
   output logic              busy,
   output logic              done
);

   localparam int NEED_W   = $clog2(PRE_MAX * SCL_MAX + 1);
   localparam int NUM_DIV  = 3;
   localparam int IDX_SCK  = 0;
   localparam int IDX_LEAD = 1;
   localparam int IDX_TAIL = 2;

   generate
      if (CNT_W < NEED_W) begin : g_bad_cnt_w
         $error("CNT_W too narrow for the largest divide product");
      end
      if (EDGE_W < 1) begin : g_bad_edge_w
         $error("EDGE_W must be at least 1");
      end
   endgenerate

   // divide products for SCK, lead and tail
   logic [1:0]       pre_sel   [NUM_DIV];
   logic [3:0]       scl_sel   [NUM_DIV];
   logic             halve_sel [NUM_DIV];
   logic [CNT_W-1:0] div_len   [NUM_DIV];

   assign pre_sel[IDX_SCK]    = sck_pre;
   assign scl_sel[IDX_SCK]    = sck_scl;
   assign halve_sel[IDX_SCK]  = dbl_rate;
   assign pre_sel[IDX_LEAD]   = lead_pre;
   assign scl_sel[IDX_LEAD]   = lead_scl;
   assign halve_sel[IDX_LEAD] = 1'b0;
   assign pre_sel[IDX_TAIL]   = tail_pre;
   assign scl_sel[IDX_TAIL]   = tail_scl;
   assign halve_sel[IDX_TAIL] = 1'b0;

   genvar g;
   generate
      for (g = 0; g < NUM_DIV; g++) begin : g_div
         spi_tmr_ratio #(
            .CNT_W    (CNT_W),
            .HALVE_EN (HALVE_EN && (g == IDX_SCK))
         ) u_ratio (
            .pre   (pre_sel[g]),
            .scl   (scl_sel[g]),
            .halve (halve_sel[g]),
            .len   (div_len[g])
         );
      end
   endgenerate

   logic [CNT_W-1:0] live_hi, live_lo;
   assign live_hi = (div_len[IDX_SCK] + CNT_W'(1)) >> 1;
   assign live_lo = div_len[IDX_SCK] >> 1;

   // state and captured frame settings
   tmr_state_e        st, st_d;
   logic [EDGE_W-1:0] slots, slots_d;
   logic [CNT_W-1:0]  lat_hi, lat_lo, lat_tail;
   logic [EDGE_W-1:0] lat_edges;
   logic              lat_cpha, lat_cont;
   logic              sck_q, sck_d, cs_q, cs_d, done_q, done_d;

   logic              cnt_ld, cnt_zero;
   logic [CNT_W-1:0]  cnt_val;

   spi_tmr_dncnt #(.W(CNT_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_ld),
      .load_val (cnt_val),
      .zero     (cnt_zero)
   );

   // live values are used on the accepting edge, captured ones afterwards
   logic              use_live, accept, do_enter, do_exit, slot_lvl, base_lvl;
   logic [CNT_W-1:0]  eff_hi, eff_lo, eff_tail;
   logic [EDGE_W-1:0] eff_edges;
   logic              eff_cpha, eff_cont;

   assign use_live  = (st == ST_IDLE);
   assign eff_hi    = use_live ? live_hi            : lat_hi;
   assign eff_lo    = use_live ? live_lo            : lat_lo;
   assign eff_tail  = use_live ? div_len[IDX_TAIL]  : lat_tail;
   assign eff_edges = use_live ? edge_num           : lat_edges;
   assign eff_cpha  = use_live ? cpha               : lat_cpha;
   assign eff_cont  = use_live ? cont_cs            : lat_cont;
   assign base_lvl  = use_live ? cpol               : sck_q;

   always_comb begin
      st_d     = st;
      slots_d  = slots;
      sck_d    = sck_q;
      cs_d     = cs_q;
      done_d   = 1'b0;
      cnt_ld   = 1'b0;
      cnt_val  = '0;
      accept   = 1'b0;
      do_enter = 1'b0;
      do_exit  = 1'b0;
      slot_lvl = 1'b0;

      case (st)
         ST_IDLE: begin
            sck_d = cpol;
            if (start && !queue_halt) begin
               accept = 1'b1;
               cs_d   = 1'b0;
               if (cont_cs) begin
                  do_enter = 1'b1;
               end else begin
                  st_d    = ST_LEAD;
                  cnt_ld  = 1'b1;
                  cnt_val = div_len[IDX_LEAD] - CNT_W'(1);
               end
            end
         end
         ST_LEAD: begin
            if (cnt_zero) do_enter = 1'b1;
         end
         ST_SHIFT: begin
            if (cnt_zero) begin
               if (!lat_cpha) sck_d = ~sck_q;
               if (slots == EDGE_W'(1)) begin
                  do_exit = 1'b1;
               end else begin
                  slots_d  = slots - EDGE_W'(1);
                  slot_lvl = ~sck_q;
                  if (lat_cpha) sck_d = ~sck_q;
                  cnt_ld   = 1'b1;
                  cnt_val  = (slot_lvl ? lat_hi : lat_lo) - CNT_W'(1);
               end
            end
         end
         ST_TAIL: begin
            if (cnt_zero) begin
               cs_d   = 1'b1;
               done_d = 1'b1;
               st_d   = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase

      if (do_enter) begin
         if (eff_edges == '0) begin
            do_exit = 1'b1;
         end else begin
            st_d     = ST_SHIFT;
            slots_d  = eff_edges;
            slot_lvl = eff_cpha ? ~base_lvl : base_lvl;
            sck_d    = slot_lvl;
            cnt_ld   = 1'b1;
            cnt_val  = (slot_lvl ? eff_hi : eff_lo) - CNT_W'(1);
         end
      end

      if (do_exit) begin
         if (eff_cont) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
         end else begin
            st_d    = ST_TAIL;
            cnt_ld  = 1'b1;
            cnt_val = eff_tail - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         slots  <= '0;
         sck_q  <= 1'b0;
         cs_q   <= 1'b1;
         done_q <= 1'b0;
      end else begin
         st     <= st_d;
         slots  <= slots_d;
         sck_q  <= sck_d;
         cs_q   <= cs_d;
         done_q <= done_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_hi    <= '0;
         lat_lo    <= '0;
         lat_tail  <= '0;
         lat_edges <= '0;
         lat_cpha  <= 1'b0;
         lat_cont  <= 1'b0;
      end else if (accept) begin
         lat_hi    <= live_hi;
         lat_lo    <= live_lo;
         lat_tail  <= div_len[IDX_TAIL];
         lat_edges <= edge_num;
         lat_cpha  <= cpha;
         lat_cont  <= cont_cs;
      end
   end

   assign sck  = sck_q;
   assign cs_n = cs_q;
   assign done = done_q;
   assign busy = (st != ST_IDLE);

endmodule

// File: rtl/spi_clk_timer_chk.sv
module spi_clk_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic queue_halt,
   input logic cpol,
   input logic sck,
   input logic cs_n,
   input logic busy,
   input logic done
);

   AST_CS_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cs_n); // R5

   AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R7

   AST_CS_RISE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> done); // R7

   AST_HALT_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && queue_halt) |=> (!busy && $stable(cs_n))); // R8

   AST_FRAME_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(start) && !$past(queue_halt))); // R9

   AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (busy || sck == $past(cpol))); // R3

endmodule

bind spi_clk_timer spi_clk_timer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .queue_halt (queue_halt),
   .cpol       (cpol),
   .sck        (sck),
   .cs_n       (cs_n),
   .busy       (busy),
   .done       (done)
);

// File: tb/spi_clk_timer_test.sv
module spi_clk_timer_test;

   localparam int EDGE_W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, queue_halt = 1'b0, cont_cs = 1'b0, dbl_rate = 1'b0;
   logic cpol = 1'b0, cpha = 1'b0;
   logic [1:0] sck_pre = '0, lead_pre = '0, tail_pre = '0;
   logic [3:0] sck_scl = '0, lead_scl = '0, tail_scl = '0;
   logic [EDGE_W-1:0] edge_num = '0;
   logic sck, cs_n, busy, done;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc++;

   spi_clk_timer #(.EDGE_W(EDGE_W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .queue_halt(queue_halt),
      .cont_cs(cont_cs), .dbl_rate(dbl_rate), .cpol(cpol), .cpha(cpha),
      .sck_pre(sck_pre), .sck_scl(sck_scl), .lead_pre(lead_pre), .lead_scl(lead_scl),
      .tail_pre(tail_pre), .tail_scl(tail_scl), .edge_num(edge_num),
      .sck(sck), .cs_n(cs_n), .busy(busy), .done(done));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int f_pre(input int c);
      case (c)
         0: return 2;
         1: return 3;
         2: return 5;
         default: return 7;
      endcase
   endfunction

   function automatic int f_scl(input int c);
      if (c < 4) return 2 * (c + 1);
      return 2 ** c;
   endfunction

   task automatic scramble();
      start    = 1'($urandom % 2);
      cont_cs  = 1'($urandom % 2);
      dbl_rate = 1'($urandom % 2);
      cpha     = 1'($urandom % 2);
      sck_pre  = 2'($urandom);  sck_scl  = 4'($urandom);
      lead_pre = 2'($urandom);  lead_scl = 4'($urandom);
      tail_pre = 2'($urandom);  tail_scl = 4'($urandom);
      edge_num = EDGE_W'($urandom);
   endtask

   // one frame, compared cycle by cycle against the model
   task automatic run_frame(input bit c_cont, input bit c_dbl, input bit c_cpol,
                            input bit c_cpha, input int sp, input int ss,
                            input int lp, input int ls, input int tp, input int ts,
                            input int ne, input bit noisy, input string tag);
      int d, hi, lo, t0, s, eend;
      int et[64];
      int bad_sck, bad_cs, bad_dn;
      int a_sck, e_sck, a_cs, e_cs, a_dn, e_dn;
      d = f_pre(sp) * f_scl(ss);
      if (c_dbl) d = d / 2;
      hi = (d + 1) / 2;
      lo = d / 2;
      t0 = c_cont ? 0 : f_pre(lp) * f_scl(ls);
      s = 0;
      for (int j = 0; j < ne; j++) begin
         int lvl, len;
         lvl = c_cpha ? (c_cpol ^ ((j + 1) & 1)) : (c_cpol ^ (j & 1));
         len = (lvl != 0) ? hi : lo;
         et[j] = c_cpha ? (t0 + s) : (t0 + s + len);
         s += len;
      end
      eend = t0 + s + (c_cont ? 0 : f_pre(tp) * f_scl(ts));
      bad_sck = 0; bad_cs = 0; bad_dn = 0;
      a_sck = 0; e_sck = 0; a_cs = 0; e_cs = 0; a_dn = 0; e_dn = 0;

      @(negedge clk);
      cont_cs = c_cont; dbl_rate = c_dbl; cpol = c_cpol; cpha = c_cpha;
      sck_pre = 2'(sp); sck_scl = 4'(ss); lead_pre = 2'(lp); lead_scl = 4'(ls);
      tail_pre = 2'(tp); tail_scl = 4'(ts); edge_num = EDGE_W'(ne);
      start = 1'b1;
      @(negedge clk);
      for (int t = 0; t <= eend + 1; t++) begin
         int ex_s, ex_c, ex_d, ex_b, cnt;
         cnt = 0;
         for (int j = 0; j < ne; j++) if (et[j] <= t) cnt++;
         ex_s = (t <= eend) ? (c_cpol ^ (cnt & 1)) : c_cpol;
         ex_c = c_cont ? 0 : ((t < eend) ? 0 : 1);
         ex_d = (t == eend) ? 1 : 0;
         ex_b = (t < eend) ? 1 : 0;
         if (int'(sck) != ex_s) begin
            if (bad_sck == 0) begin a_sck = sck; e_sck = ex_s + 10 * t; end
            bad_sck++;
         end
         if (int'(cs_n) != ex_c) begin
            if (bad_cs == 0) begin a_cs = cs_n; e_cs = ex_c + 10 * t; end
            bad_cs++;
         end
         if (int'(done) != ex_d || int'(busy) != ex_b) begin
            if (bad_dn == 0) begin a_dn = 2 * done + busy; e_dn = 2 * ex_d + ex_b + 10 * t; end
            bad_dn++;
         end
         if (noisy && t < eend) scramble();
         else start = 1'b0;
         if (t <= eend) @(negedge clk);
      end
      start = 1'b0;
      // expected values carry the cycle offset in their tens and above
      chk(bad_sck == 0, tag, "sck waveform", a_sck, e_sck);
      chk(bad_cs == 0, c_cont ? "R6" : "R5", "cs_n timing", a_cs, e_cs);
      chk(bad_dn == 0, "R7", "done/busy timing", a_dn, e_dn);
   endtask

   initial begin
      void'($urandom(32'h5a17));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      // reset state
      chk(cs_n == 1'b1, "R5", "cs_n after reset", cs_n, 1);
      chk(sck == 1'b0, "R3", "sck idle cpol=0", sck, 0);
      chk(busy == 1'b0 && done == 1'b0, "R7", "busy/done after reset", 2 * done + busy, 0);
      cpol = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(sck == 1'b1, "R3", "sck idle cpol=1", sck, 1);

      // fastest rate: 2*2 halved gives a period of 2
      run_frame(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 8, 0, "R2");
      // odd divide 3*2/2 = 3: high 2, low 1
      run_frame(0, 1, 1, 1, 1, 0, 0, 1, 2, 0, 6, 0, "R3");
      // decode checks
      run_frame(0, 0, 0, 0, 3, 6, 1, 2, 0, 3, 4, 0, "R1");
      run_frame(0, 1, 0, 1, 0, 15, 0, 0, 0, 0, 2, 0, "R1");
      run_frame(0, 0, 1, 0, 2, 5, 3, 4, 1, 1, 4, 0, "R1");
      // edge placement for both phases on one setting
      run_frame(0, 0, 0, 0, 1, 2, 0, 1, 0, 1, 6, 0, "R4");
      run_frame(0, 0, 0, 1, 1, 2, 0, 1, 0, 1, 6, 0, "R4");
      // continuous frames keep chip select, then a normal frame releases it
      run_frame(1, 0, 0, 1, 0, 1, 3, 3, 3, 3, 4, 0, "R6");
      run_frame(1, 0, 0, 0, 1, 0, 3, 3, 3, 3, 2, 0, "R6");
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b0, "R6", "cs_n held between frames", cs_n, 0);
      run_frame(0, 0, 0, 0, 0, 0, 1, 1, 2, 1, 2, 0, "R6");
      // zero edges
      run_frame(0, 0, 0, 0, 0, 0, 2, 1, 1, 2, 0, 0, "R10");

      // halt blocks start
      @(negedge clk);
      queue_halt = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R8", "busy under halt", busy, 0);
      chk(cs_n == 1'b1, "R8", "cs_n under halt", cs_n, 1);
      queue_halt = 1'b0;

      // random frames with mid-frame starts and setting changes
      for (int i = 0; i < 30; i++) begin
         run_frame(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                   int'($urandom % 4), int'($urandom % 8), int'($urandom % 4), int'($urandom % 7),
                   int'($urandom % 4), int'($urandom % 7), 2 * int'($urandom % 6),
                   1'b1, "R9");
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      wait (cyc > 190000);
      if (!finished) begin
         chk(1'b0, "R7", "watchdog expired", cyc, 190000);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule